// File: doc/BRIEF.md
# Sample Buffer Interrupt Controller

This block keeps four independent sample queues for a bio-sensing front end: one holds the electrical heart-signal samples, two hold the two optical channels, and one holds heartbeat-interval results. The acquisition side pushes samples with per-queue write strobes. The host side pops them with per-queue read strobes. Each queue has a programmable fill threshold. Each queue reports three level events: threshold crossed, full and drained.

The twelve events are latched in a sticky status register. A matching enable register masks them. A single interrupt line is raised while any enabled status bit is set. The host reads the status word to find the cause and writes ones back to clear those bits. When electrical acquisition is switched on, the block first places two zero samples in the electrical queue, ahead of the first real sample.

Top module: `sbuf_irq_ctrl`

## Requirements
- R1: Each queue holds 24-bit samples at 4 bytes per sample. The electrical queue has 256 entries (1 kB). The two optical queues split 2 kB, 256 entries each. The interval queue has 256 entries (1 kB). Queue index b is 0 for electrical, 1 for optical 1, 2 for optical 2 and 3 for interval. Samples come out in the order they were written. Read data of queue b sits on `rd_dat_o[24b+23:24b]` and is updated on the clock edge that takes the read strobe.
- R2: A write to a queue that already holds 256 entries is dropped and leaves the stored contents unchanged.
- R3: A read from an empty queue returns zero and does not move the read position. A later write followed by a read returns the written sample.
- R4: With a non-zero threshold T in `thr_i[9b+8:9b]`, the threshold event of queue b fires on the accepted write that raises the fill level from T-1 to T. It fires again only after the level has fallen below T and then risen to T again. A threshold of 0 never fires.
- R5: The full event fires on the write that raises the level to 256. The drained event fires on the read that lowers the level to 0.
- R6: Status bit 3b+k latches the event of queue b and kind k, where k=0 is threshold, k=1 is full and k=2 is drained. Once set, a bit stays set until the host clears it.
- R7: With `reg_addr_i`=1, a register write clears every status bit written as 1 and leaves bits written as 0 unchanged. An event in the same cycle as the clear keeps its bit set.
- R8: With `reg_addr_i`=0, a register write loads the 12-bit enable word, and the host can read it back. `irq_o` is high exactly when some status bit and its enable bit are both set. It follows the registered values without further delay.
- R9: On a rising edge of `ecg_run_i`, the electrical queue receives two zero samples in the next two cycles. Electrical write strobes in those two cycles are ignored.
- R10: After reset all queues are empty, status and enable are zero, `irq_o` is low and all read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecg_run_i | input | 1 | Electrical acquisition enable; its rising edge inserts two zero samples |
| wr_stb_i | input | 4 | Per-queue write strobe |
| wr_dat_i | input | 96 | Per-queue write sample, 24 bits per queue |
| rd_stb_i | input | 4 | Per-queue read strobe |
| rd_dat_o | output | 96 | Per-queue read sample, 24 bits per queue |
| thr_i | input | 36 | Per-queue threshold, 9 bits per queue |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects enable, 1 selects status |
| reg_wdat_i | input | 12 | Register write data |
| reg_rdat_o | output | 12 | Register read data for the selected register |
| irq_o | output | 1 | Interrupt, high while an enabled status bit is set |

## Verification
Short bursts through one optical queue check ordering and the drained event with no threshold programmed. A threshold sequence goes up to the threshold, beyond it, down below it and back up. This separates a single crossing event from a level comparison that refires while the level stays at or above the threshold. A full fill of the interval queue, one write too many, a complete drain and one read too many show that the drop, full, drained and zero-on-empty behaviours hold at the 256-entry limit. Toggling the electrical enable while strobing real samples shows whether the two zeros land first and the overlapping strobes are discarded. Partial clear and mask patterns on the status and enable words show whether each source is attributed to its own bit.

// File: rtl/sbuf_pkg.sv
`timescale 1ns/1ps
package sbuf_pkg;
    localparam int NUM_BUF  = 4;
    localparam int NUM_KIND = 3;
    localparam int NUM_SRC  = NUM_BUF * NUM_KIND;

    // event kinds inside one queue's group of status bits
    localparam int K_THR   = 0;
    localparam int K_FULL  = 1;
    localparam int K_EMPTY = 2;

    // register select
    localparam logic ADDR_EN = 1'b0;
    localparam logic ADDR_ST = 1'b1;
endpackage

// File: rtl/sbuf_fifo.sv
`timescale 1ns/1ps
module sbuf_fifo #(
    parameter int DEPTH = 256,
    parameter int DW    = 24,
    parameter int TW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_i,
    input  logic [TW-1:0] thr_i,
    output logic [DW-1:0] rdata_o,
    output logic          ev_thr_o,
    output logic          ev_full_o,
    output logic          ev_empty_o
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVW = $clog2(DEPTH + 1);
    localparam logic [LVW-1:0] LV_FULL = LVW'(DEPTH);
    localparam logic [LVW-1:0] LV_ONE  = LVW'(1);
    localparam logic [LVW-1:0] LV_LAST = LVW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0]  wp;
        logic [AW-1:0]  rp;
        logic [LVW-1:0] lvl;
        logic [DW-1:0]  rdat;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic wr_ok, rd_ok;
    logic [TW-1:0] lvl_nx;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d  = st_q;
        wr_ok = wr_i && (st_q.lvl != LV_FULL);
        rd_ok = rd_i && (st_q.lvl != '0);
        if (wr_ok) st_d.wp = ptr_inc(st_q.wp);
        if (rd_ok) st_d.rp = ptr_inc(st_q.rp);
        if (rd_i)  st_d.rdat = rd_ok ? mem_q[st_q.rp] : '0;
        case ({wr_ok, rd_ok})
            2'b10:   st_d.lvl = st_q.lvl + LV_ONE;
            2'b01:   st_d.lvl = st_q.lvl - LV_ONE;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[st_q.wp] <= wdata_i;
    end

    assign lvl_nx     = TW'(st_q.lvl) + TW'(1);
    assign ev_thr_o   = wr_ok && !rd_ok && (thr_i != '0) && (lvl_nx == thr_i);
    assign ev_full_o  = wr_ok && !rd_ok && (st_q.lvl == LV_LAST);
    assign ev_empty_o = rd_ok && !wr_ok && (st_q.lvl == LV_ONE);
    assign rdata_o    = st_q.rdat;

    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= LV_FULL);
    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !rd_i && st_q.lvl == LV_FULL) |=> ($stable(st_q.wp) && st_q.lvl == LV_FULL));
    // R3
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && st_q.lvl == '0) |=> (rdata_o == '0 && $stable(st_q.rp)));
    // R5
    full_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_full_o |=> (st_q.lvl == LV_FULL));
    // R5
    empty_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_empty_o |=> (st_q.lvl == '0));
endmodule

// File: rtl/sbuf_ecg_pad.sv
`timescale 1ns/1ps
module sbuf_ecg_pad #(
    parameter int DW  = 24,
    parameter int PAD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          wr_o,
    output logic [DW-1:0] wdata_o
);
    localparam int CW = $clog2(PAD + 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] pad;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = run_i;
        if (run_i && !st_q.run)     st_d.pad = CW'(PAD);
        else if (st_q.pad != '0)    st_d.pad = st_q.pad - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_o    = (st_q.pad != '0) || wr_i;
    assign wdata_o = (st_q.pad != '0) ? '0 : wdata_i;

    // R9
    pad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !st_q.run) |=> (wr_o && wdata_o == '0));
endmodule

// File: rtl/sbuf_irq_regs.sv
`timescale 1ns/1ps
module sbuf_irq_regs
    import sbuf_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev_i,
    input  logic            we_i,
    input  logic            addr_i,
    input  logic [NSRC-1:0] wdat_i,
    output logic [NSRC-1:0] rdat_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] st;
    } st_t;

    st_t st_d, st_q;
    logic [NSRC-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = (we_i && addr_i == ADDR_ST) ? wdat_i : '0;
        if (we_i && addr_i == ADDR_EN) st_d.en = wdat_i;
        st_d.st = (st_q.st & ~clr) | ev_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdat_o = (addr_i == ADDR_ST) ? st_q.st : st_q.en;
    assign irq_o  = |(st_q.st & st_q.en);

    // R6
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((st_q.st & $past(ev_i)) == $past(ev_i)));
    // R7
    w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_ST) |=> ((($past(st_q.st) & ~$past(wdat_i)) & ~st_q.st) == '0));
    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(ev_i) != '0 || $past(we_i)));
endmodule

// File: rtl/sbuf_irq_ctrl.sv
`timescale 1ns/1ps
module sbuf_irq_ctrl
    import sbuf_pkg::*;
#(
    parameter int DW           = 24,
    parameter int SAMPLE_BYTES = 4,
    parameter int ECG_BYTES    = 1024,
    parameter int PPG_BYTES    = 2048,
    parameter int HBI_BYTES    = 1024,
    parameter int PAD_SAMPLES  = 2,
    parameter int THR_W        = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ecg_run_i,
    input  logic [NUM_BUF-1:0]     wr_stb_i,
    input  logic [NUM_BUF*DW-1:0]  wr_dat_i,
    input  logic [NUM_BUF-1:0]     rd_stb_i,
    output logic [NUM_BUF*DW-1:0]  rd_dat_o,
    input  logic [NUM_BUF*THR_W-1:0] thr_i,
    input  logic                   reg_we_i,
    input  logic                   reg_addr_i,
    input  logic [NUM_SRC-1:0]     reg_wdat_i,
    output logic [NUM_SRC-1:0]     reg_rdat_o,
    output logic                   irq_o
);
    localparam int ECG_D = ECG_BYTES / SAMPLE_BYTES;
    localparam int PPG_D = PPG_BYTES / (2 * SAMPLE_BYTES);
    localparam int HBI_D = HBI_BYTES / SAMPLE_BYTES;

    logic [NUM_SRC-1:0] ev_all;

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        localparam int DEP = (b == 0) ? ECG_D : ((b == NUM_BUF - 1) ? HBI_D : PPG_D);
        logic          wr_b;
        logic [DW-1:0] wd_b;

        if (b == 0) begin : g_pad
            sbuf_ecg_pad #(.DW(DW), .PAD(PAD_SAMPLES)) u_pad (
                .clk     (clk),
                .rst_n   (rst_n),
                .run_i   (ecg_run_i),
                .wr_i    (wr_stb_i[b]),
                .wdata_i (wr_dat_i[b*DW +: DW]),
                .wr_o    (wr_b),
                .wdata_o (wd_b)
            );
        end else begin : g_direct
            assign wr_b = wr_stb_i[b];
            assign wd_b = wr_dat_i[b*DW +: DW];
        end

        sbuf_fifo #(.DEPTH(DEP), .DW(DW), .TW(THR_W)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (wr_b),
            .wdata_i    (wd_b),
            .rd_i       (rd_stb_i[b]),
            .thr_i      (thr_i[b*THR_W +: THR_W]),
            .rdata_o    (rd_dat_o[b*DW +: DW]),
            .ev_thr_o   (ev_all[b*NUM_KIND + K_THR]),
            .ev_full_o  (ev_all[b*NUM_KIND + K_FULL]),
            .ev_empty_o (ev_all[b*NUM_KIND + K_EMPTY])
        );
    end

    sbuf_irq_regs #(.NSRC(NUM_SRC)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev_all),
        .we_i   (reg_we_i),
        .addr_i (reg_addr_i),
        .wdat_i (reg_wdat_i),
        .rdat_o (reg_rdat_o),
        .irq_o  (irq_o)
    );
endmodule

// File: tb/sim_sbuf_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sbuf_irq_ctrl;
    localparam int DW  = 24;
    localparam int TW  = 9;
    localparam int DEP = 256;
    localparam int WD  = 100000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          ecg_run = 1'b0;
    logic [3:0]    wr_stb = '0;
    logic [4*DW-1:0] wr_dat = '0;
    logic [3:0]    rd_stb = '0;
    logic [4*DW-1:0] rd_dat;
    logic [4*TW-1:0] thr = '0;
    logic          reg_we = 1'b0;
    logic          reg_addr = 1'b0;
    logic [11:0]   reg_wdat = '0;
    logic [11:0]   reg_rdat;
    logic          irq;

    sbuf_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ecg_run_i(ecg_run),
        .wr_stb_i(wr_stb), .wr_dat_i(wr_dat), .rd_stb_i(rd_stb), .rd_dat_o(rd_dat),
        .thr_i(thr), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdat_i(reg_wdat), .reg_rdat_o(reg_rdat), .irq_o(irq)
    );

    // reference model
    logic [DW-1:0] mq [4][$];
    logic [11:0]   est = '0;
    logic [TW-1:0] mthr [4] = '{default: '0};

    // scoreboard for read results
    logic [DW-1:0] exp_d [$];
    string         exp_t [$];

    int tot = 0, bad = 0, mtot = 0, mbad = 0;

    task automatic check(string r, logic [31:0] act, logic [31:0] exp);
        tot++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic void m_wr(int b, logic [DW-1:0] d);
        int l = mq[b].size();
        if (l < DEP) begin
            if (mthr[b] != 0 && l + 1 == int'(mthr[b])) est[3*b] = 1'b1;
            if (l + 1 == DEP) est[3*b+1] = 1'b1;
            mq[b].push_back(d);
        end
    endfunction

    task automatic do_wr(int b, logic [DW-1:0] d);
        @(negedge clk);
        wr_stb = '0;
        wr_stb[b] = 1'b1;
        wr_dat[b*DW +: DW] = d;
        m_wr(b, d);
        @(negedge clk);
        wr_stb = '0;
    endtask

    task automatic do_rd(int b);
        @(negedge clk);
        rd_stb = '0;
        rd_stb[b] = 1'b1;
        if (mq[b].size() == 0) begin
            exp_d.push_back('0);
            exp_t.push_back("R3 empty read");
        end else begin
            if (mq[b].size() == 1) est[3*b+2] = 1'b1;
            exp_d.push_back(mq[b].pop_front());
            exp_t.push_back("R1 read order");
        end
        @(negedge clk);
        rd_stb = '0;
    endtask

    task automatic reg_write(logic a, logic [11:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdat = v;
        if (a) est = est & ~v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(logic a, output logic [11:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdat;
    endtask

    task automatic set_thr(int b, logic [TW-1:0] t);
        @(negedge clk);
        thr[b*TW +: TW] = t;
        mthr[b] = t;
    endtask

    // monitor: compares each read result with the scoreboard
    always @(posedge clk) begin
        if (rst_n && rd_stb != '0) begin
            int b = 0;
            logic [DW-1:0] e;
            string t;
            for (int i = 0; i < 4; i++) if (rd_stb[i]) b = i;
            #1;
            e = exp_d.pop_front();
            t = exp_t.pop_front();
            mtot++;
            if (rd_dat[b*DW +: DW] !== e) begin
                mbad++;
                $display("FAIL %s buf=%0d actual=%h expected=%h", t, b, rd_dat[b*DW +: DW], e);
            end
        end
    end

    task automatic run_all();
        logic [11:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        reg_read(1'b1, v); check("R10 status after reset", 32'(v), 32'h0);
        reg_read(1'b0, v); check("R10 enable after reset", 32'(v), 32'h0);
        check("R10 irq after reset", 32'(irq), 32'h0);
        check("R10 read data after reset", 32'(rd_dat[DW-1:0] | rd_dat[2*DW +: DW]), 32'h0);

        // pattern A: short burst through optical 2, no threshold
        for (int i = 0; i < 5; i++) do_wr(2, 24'h000100 + 24'(i));
        for (int i = 0; i < 5; i++) do_rd(2);
        reg_read(1'b1, v); check("R6 drained bit of queue 2", 32'(v), 32'(est));
        check("R5 drained event at bit 8", 32'(v[8]), 32'h1);
        reg_write(1'b1, 12'hFFF);
        reg_read(1'b1, v); check("R7 clear all", 32'(v), 32'h0);

        // pattern B: threshold crossing on optical 1
        set_thr(1, 9'd4);
        for (int i = 0; i < 3; i++) do_wr(1, 24'h0A0000 + 24'(i));
        reg_read(1'b1, v); check("R4 no event below threshold", 32'(v[3]), 32'h0);
        do_wr(1, 24'h0A0003);
        reg_read(1'b1, v); check("R4 event at threshold", 32'(v[3]), 32'h1);
        check("R8 masked irq", 32'(irq), 32'h0);
        reg_write(1'b0, 12'h008);
        #1 check("R8 irq when enabled", 32'(irq), 32'h1);
        do_wr(1, 24'h0A0004);
        reg_write(1'b1, 12'h008);
        do_wr(1, 24'h0A0005);
        reg_read(1'b1, v); check("R4 no refire above threshold", 32'(v[3]), 32'h0);
        #1 check("R8 irq low after clear", 32'(irq), 32'h0);
        for (int i = 0; i < 3; i++) do_rd(1);
        do_wr(1, 24'h0A0006);
        reg_read(1'b1, v); check("R4 refire after dropping below", 32'(v[3]), 32'h1);
        for (int i = 0; i < 4; i++) do_rd(1);
        reg_read(1'b1, v); check("R6 status after optical 1 drain", 32'(v), 32'(est));

        // pattern C: partial clears
        reg_write(1'b1, 12'h000);
        reg_read(1'b1, v); check("R7 writing zero keeps bits", 32'(v), 32'h028);
        reg_write(1'b1, 12'h020);
        reg_read(1'b1, v); check("R7 clear one bit only", 32'(v), 32'h008);
        reg_write(1'b1, 12'hFFF);
        reg_write(1'b0, 12'h000);

        // pattern D: fill interval queue to the limit
        for (int i = 0; i < DEP - 1; i++) do_wr(3, 24'(i * 7 + 3) ^ 24'h5C0000);
        reg_read(1'b1, v); check("R5 no full before last entry", 32'(v[10]), 32'h0);
        do_wr(3, 24'hFEEDEE);
        reg_read(1'b1, v); check("R5 full event at bit 10", 32'(v[10]), 32'h1);
        do_wr(3, 24'h123456);
        reg_write(1'b0, 12'h001);
        #1 check("R8 other source enabled only", 32'(irq), 32'h0);
        reg_write(1'b0, 12'h400);
        #1 check("R8 full source enabled", 32'(irq), 32'h1);
        reg_read(1'b0, v); check("R8 enable readback", 32'(v), 32'h400);
        for (int i = 0; i < DEP; i++) do_rd(3);
        reg_read(1'b1, v); check("R5 drained event at bit 11", 32'(v[11]), 32'h1);
        check("R2 dropped write left no extra entry", 32'(mq[3].size()), 32'h0);
        do_rd(3);
        do_wr(3, 24'hABCDEF);
        do_rd(3);
        reg_write(1'b1, 12'hFFF);
        reg_write(1'b0, 12'h000);

        // pattern E: electrical start inserts two zeros
        @(negedge clk);
        ecg_run = 1'b1;
        m_wr(0, '0);
        m_wr(0, '0);
        @(negedge clk);
        wr_stb[0] = 1'b1; wr_dat[DW-1:0] = 24'h111111;
        @(negedge clk);
        @(negedge clk);
        wr_stb = '0;
        do_wr(0, 24'h5A5A5A);
        do_rd(0); do_rd(0); do_rd(0); do_rd(0);
        reg_read(1'b1, v); check("R9 electrical drained after pad and sample", 32'(v), 32'(est));
        check("R9 pad plus one sample consumed", 32'(mq[0].size()), 32'h0);

        reg_write(1'b0, 12'hFFF);
        reg_read(1'b0, v); check("R8 enable readback all", 32'(v), 32'hFFF);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            begin : flow
                run_all();
            end
            begin : dog
                repeat (WD) @(posedge clk);
                tot++; bad++;
                $display("FAIL R10 watchdog actual=running expected=finished");
            end
        join_any
        disable fork;
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", tot + mtot, bad + mbad);
        $finish;
    end
endmodule